// File: doc/BRIEF.md
# Clock Select and Output Gating Control

This block sits between the configuration registers of a system clock generator and its output buffers. From one control byte and a hardware select pin it produces the 3-bit frequency code that steers the synthesizer. It also decodes the operating mode into three flags: spread-spectrum enable, test mode and a global output float.

Three further bytes carry one enable per clock output. These cover two CPU clocks, seven PCI clocks (one of them the free-running one), an interrupt-controller clock and a reference clock. Each enable is carried into the clock domain of its output and gates that clock without producing a shortened pulse.

A strap pin shared with another function is sampled while reset is held. It decides whether the selectable output carries the 24 MHz or the 48 MHz input clock. The synthesized clocks arrive as inputs. Frequency synthesis and spread modulation happen elsewhere.

Top module: `clkctl_top`

## Requirements
- R1: With `ctl_byte[3]` = 0, `freq_code` follows `sel_hi_pin`: 3'b111 (CPU 100 / PCI 33.3 MHz) when the pin is high and 3'b011 (CPU 66.6 / PCI 33.3 MHz) when it is low.
- R2: With `ctl_byte[3]` = 1, `freq_code` equals `ctl_byte[6:4]` and the pin has no effect.
- R3: `ctl_byte[1:0]` selects the mode: 2'b10 sets `ssc_en`, 2'b01 sets `test_mode`, 2'b11 sets `out_hiz`, and 2'b00 sets none of them. At most one flag is high at a time.
- R4: Each gated output runs as a copy of its input clock when its enable bit is 1 and is held low when the bit is 0. `cpu_clk_out[0]` uses `cpu_byte[0]` and `cpu_clk_out[1]` uses `cpu_byte[2]`. `pci_clk_out[3:0]` use `pci_byte[3:0]`. `pci_clk_out[4]` uses `pci_byte[5]` and `pci_clk_out[5]` uses `pci_byte[6]`. The free-running `pci_clk_out[6]` uses `pci_byte[7]`. `apic_clk_out` uses `aux_byte[5]`.
- R5: `ref_clk_out` runs only when both `aux_byte[1]` and `aux_byte[0]` are 1. If they disagree, the output is held low.
- R6: Reserved bits `ctl_byte[7]`, `ctl_byte[2]` and `pci_byte[4]`, and every `cpu_byte`/`aux_byte` bit not named in R4/R5, have no effect on any output.
- R7: In float mode (`ctl_byte[1:0]` = 2'b11), every gated output is held low whatever its enable bit says.
- R8: `strap_pin` is sampled while `cfg_rst_n` is low. After release `sel_clk_out` copies `clk24_in` if the sampled value was 1 and `clk48_in` if it was 0. Later changes of the pin are ignored until the next reset.
- R9: An enable takes effect only while its output clock is low, so every high pulse of a gated output is a full high phase of its input clock.
- R10: While `cfg_rst_n` is low, every gated output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Register-side clock |
| cfg_rst_n | input | 1 | Active-low reset, also clears the gate stages |
| sel_hi_pin | input | 1 | Hardware frequency select, 1 = CPU 100 MHz |
| strap_pin | input | 1 | Shared strap, sampled during reset |
| ctl_byte | input | 8 | Frequency source, code and mode |
| pci_byte | input | 8 | PCI output enables |
| cpu_byte | input | 8 | CPU output enables |
| aux_byte | input | 8 | Interrupt-controller and reference enables |
| cpu_clk_in | input | 1 | CPU-rate clock from the synthesizer |
| pci_clk_in | input | 1 | PCI-rate clock |
| apic_clk_in | input | 1 | Interrupt-controller clock |
| ref_clk_in | input | 1 | Reference clock |
| clk48_in | input | 1 | 48 MHz clock |
| clk24_in | input | 1 | 24 MHz clock |
| freq_code | output | 3 | Effective frequency code |
| ssc_en | output | 1 | Spread-spectrum enable |
| test_mode | output | 1 | Test mode flag |
| out_hiz | output | 1 | Float all output pads |
| cpu_clk_out | output | 2 | Gated CPU clocks |
| pci_clk_out | output | 7 | Gated PCI clocks, bit 6 free-running |
| apic_clk_out | output | 1 | Gated interrupt-controller clock |
| ref_clk_out | output | 1 | Gated reference clock |
| sel_clk_out | output | 1 | 24 or 48 MHz by strap |

## Verification
The assertions watch the frequency-source choice, the mutual exclusion of the mode flags and the stability of the sampled strap on every register clock. They also check that, once the configuration has been quiet long enough for all domains to settle, no CPU, PCI or reference output is high while its enable or the float mode says it must be low. Only the bench scenarios show the positive side. Those scenarios cover an enabled output actually tracking its clock, the full bit map swept over all 256 enable patterns, the strap choice across two resets, and the absence of runt pulses, which the bench measures as high-pulse widths while the enables toggle.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;
   typedef enum logic [1:0] {
      MODE_RUN    = 2'b00,
      MODE_TEST   = 2'b01,
      MODE_SPREAD = 2'b10,
      MODE_HIZ    = 2'b11
   } run_mode_e;

   localparam int N_CPU       = 2;
   localparam int N_PCI       = 7;
   localparam int CODE_W      = 3;
   localparam int CTL_SRC_BIT = 3;
   localparam int CTL_CODE_LO = 4;
   localparam int APIC_EN_BIT = 5;

   // CPU enables sit on even bit positions
   function automatic int cpu_en_pos(input int idx);
      return idx * 2;
   endfunction

   // PCI enables skip the reserved position 4; index 6 is the free-running clock
   function automatic int pci_en_pos(input int idx);
      return (idx < 4) ? idx : idx + 1;
   endfunction
endpackage

// File: rtl/clkctl_decode.sv
module clkctl_decode
   import clkctl_pkg::*;
#(
   parameter logic [CODE_W-1:0] HW_HI_CODE = 3'b111,
   parameter logic [CODE_W-1:0] HW_LO_CODE = 3'b011
) (
   input  logic [7:0]        ctl_byte,
   input  logic              sel_hi,
   input  logic [7:0]        pci_byte,
   input  logic [7:0]        cpu_byte,
   input  logic [7:0]        aux_byte,
   output logic [CODE_W-1:0] freq_code,
   output logic              ssc_en,
   output logic              test_mode,
   output logic              hiz,
   output logic [N_CPU-1:0]  cpu_en,
   output logic [N_PCI-1:0]  pci_en,
   output logic              apic_en,
   output logic              ref_en
);
   run_mode_e mode;

   always_comb begin
      mode      = run_mode_e'(ctl_byte[1:0]);
      freq_code = ctl_byte[CTL_SRC_BIT] ? ctl_byte[CTL_CODE_LO +: CODE_W]
                                        : (sel_hi ? HW_HI_CODE : HW_LO_CODE);
      ssc_en    = (mode == MODE_SPREAD);
      test_mode = (mode == MODE_TEST);
      hiz       = (mode == MODE_HIZ);
      apic_en   = aux_byte[APIC_EN_BIT] & ~hiz;
      // both halves of the reference driver must agree before it runs
      ref_en    = aux_byte[1] & aux_byte[0] & ~hiz;
   end

   for (genvar i = 0; i < N_CPU; i++) begin : g_cpu_map
      assign cpu_en[i] = cpu_byte[cpu_en_pos(i)] & ~hiz;
   end

   for (genvar j = 0; j < N_PCI; j++) begin : g_pci_map
      assign pci_en[j] = pci_byte[pci_en_pos(j)] & ~hiz;
   end

   logic unused_bits;
   assign unused_bits = ^{ctl_byte[7], ctl_byte[2], pci_byte[4],
                          cpu_byte[7:3], cpu_byte[1], aux_byte[7:6], aux_byte[4:2]};
endmodule

// File: rtl/clkctl_strap.sv
module clkctl_strap (
   input  logic clk,
   input  logic rst_n,
   input  logic strap_in,
   output logic strap_q
);
   // tracks the pin while reset is held, then freezes
   always_ff @(posedge clk) begin
      if (!rst_n) strap_q <= strap_in;
   end
endmodule

// File: rtl/clkctl_gate.sv
module clkctl_gate #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_in,
   input  logic rst_n,
   input  logic en_req,
   output logic clk_out
);
   if (!(SYNC_STAGES == 0 || SYNC_STAGES >= 2)) begin : g_bad_stages
      $error("clkctl_gate: SYNC_STAGES must be 0 or at least 2");
   end

   logic en_dom;
   logic en_low;

   if (SYNC_STAGES == 0) begin : g_direct
      assign en_dom = en_req;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk_in or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[SYNC_STAGES-2:0], en_req};
      end
      assign en_dom = chain[SYNC_STAGES-1];
   end

   // updated on the falling edge, so it only moves during the low phase
   always_ff @(negedge clk_in or negedge rst_n) begin
      if (!rst_n) en_low <= 1'b0;
      else        en_low <= en_dom;
   end

   assign clk_out = clk_in & en_low;
endmodule

// File: rtl/clkctl_top.sv
module clkctl_top
   import clkctl_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter logic [CODE_W-1:0] HW_HI_CODE  = 3'b111,
   parameter logic [CODE_W-1:0] HW_LO_CODE  = 3'b011
) (
   input  logic              cfg_clk,
   input  logic              cfg_rst_n,
   input  logic              sel_hi_pin,
   input  logic              strap_pin,
   input  logic [7:0]        ctl_byte,
   input  logic [7:0]        pci_byte,
   input  logic [7:0]        cpu_byte,
   input  logic [7:0]        aux_byte,
   input  logic              cpu_clk_in,
   input  logic              pci_clk_in,
   input  logic              apic_clk_in,
   input  logic              ref_clk_in,
   input  logic              clk48_in,
   input  logic              clk24_in,
   output logic [CODE_W-1:0] freq_code,
   output logic              ssc_en,
   output logic              test_mode,
   output logic              out_hiz,
   output logic [N_CPU-1:0]  cpu_clk_out,
   output logic [N_PCI-1:0]  pci_clk_out,
   output logic              apic_clk_out,
   output logic              ref_clk_out,
   output logic              sel_clk_out
);
   logic [N_CPU-1:0] cpu_en;
   logic [N_PCI-1:0] pci_en;
   logic             apic_en;
   logic             ref_en;
   logic             strap_q;

   clkctl_decode #(
      .HW_HI_CODE(HW_HI_CODE),
      .HW_LO_CODE(HW_LO_CODE)
   ) u_decode (
      .ctl_byte (ctl_byte),
      .sel_hi   (sel_hi_pin),
      .pci_byte (pci_byte),
      .cpu_byte (cpu_byte),
      .aux_byte (aux_byte),
      .freq_code(freq_code),
      .ssc_en   (ssc_en),
      .test_mode(test_mode),
      .hiz      (out_hiz),
      .cpu_en   (cpu_en),
      .pci_en   (pci_en),
      .apic_en  (apic_en),
      .ref_en   (ref_en)
   );

   clkctl_strap u_strap (
      .clk     (cfg_clk),
      .rst_n   (cfg_rst_n),
      .strap_in(strap_pin),
      .strap_q (strap_q)
   );

   for (genvar i = 0; i < N_CPU; i++) begin : g_cpu_gate
      clkctl_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
         .clk_in(cpu_clk_in), .rst_n(cfg_rst_n), .en_req(cpu_en[i]), .clk_out(cpu_clk_out[i]));
   end

   for (genvar j = 0; j < N_PCI; j++) begin : g_pci_gate
      clkctl_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
         .clk_in(pci_clk_in), .rst_n(cfg_rst_n), .en_req(pci_en[j]), .clk_out(pci_clk_out[j]));
   end

   clkctl_gate #(.SYNC_STAGES(SYNC_STAGES)) u_apic_gate (
      .clk_in(apic_clk_in), .rst_n(cfg_rst_n), .en_req(apic_en), .clk_out(apic_clk_out));

   clkctl_gate #(.SYNC_STAGES(SYNC_STAGES)) u_ref_gate (
      .clk_in(ref_clk_in), .rst_n(cfg_rst_n), .en_req(ref_en), .clk_out(ref_clk_out));

   assign sel_clk_out = strap_q ? clk24_in : clk48_in;
endmodule

// File: rtl/clkctl_chk.sv
module clkctl_chk
   import clkctl_pkg::*;
#(
   parameter int QUIET = 128
) (
   input logic              cfg_clk,
   input logic              cfg_rst_n,
   input logic              sel_hi_pin,
   input logic [7:0]        ctl_byte,
   input logic [7:0]        pci_byte,
   input logic [7:0]        cpu_byte,
   input logic [7:0]        aux_byte,
   input logic [CODE_W-1:0] freq_code,
   input logic              ssc_en,
   input logic              test_mode,
   input logic              out_hiz,
   input logic [N_CPU-1:0]  cpu_clk_out,
   input logic [N_PCI-1:0]  pci_clk_out,
   input logic              ref_clk_out,
   input logic              strap_q
);
   if (QUIET < 1 || QUIET > 255) begin : g_bad_quiet
      $error("clkctl_chk: QUIET must lie in 1..255");
   end

   logic [31:0] cfg_prev;
   logic [7:0]  quiet_cnt;
   logic        settled;

   always_ff @(posedge cfg_clk or negedge cfg_rst_n) begin
      if (!cfg_rst_n) begin
         cfg_prev  <= '0;
         quiet_cnt <= '0;
      end else begin
         cfg_prev <= {ctl_byte, pci_byte, cpu_byte, aux_byte};
         if (cfg_prev != {ctl_byte, pci_byte, cpu_byte, aux_byte}) quiet_cnt <= '0;
         else if (quiet_cnt != 8'(QUIET))                          quiet_cnt <= quiet_cnt + 8'd1;
      end
   end
   assign settled = (quiet_cnt == 8'(QUIET));

   logic [N_PCI-1:0] pci_allow;
   logic [N_CPU-1:0] cpu_allow;
   always_comb begin
      pci_allow = {pci_byte[7:5], pci_byte[3:0]} & {N_PCI{~out_hiz}};
      cpu_allow = {cpu_byte[2], cpu_byte[0]} & {N_CPU{~out_hiz}};
   end

   p_pin_code_r1: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
      !ctl_byte[3] |-> freq_code == (sel_hi_pin ? 3'b111 : 3'b011));

   p_reg_code_r2: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
      ctl_byte[3] |-> freq_code == ctl_byte[6:4]);

   p_mode_excl_r3: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
      $onehot0({ssc_en, test_mode, out_hiz}));

   p_pci_off_r4: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
      settled |-> (pci_clk_out & ~pci_allow) == '0);

   p_cpu_off_r4: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
      settled |-> (cpu_clk_out & ~cpu_allow) == '0);

   p_ref_pair_r5: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
      (settled && !(aux_byte[1] && aux_byte[0])) |-> !ref_clk_out);

   p_hiz_quiet_r7: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
      (settled && out_hiz) |-> (pci_clk_out == '0 && cpu_clk_out == '0 && !ref_clk_out));

   p_strap_hold_r8: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
      $past(cfg_rst_n) |-> $stable(strap_q));
endmodule

bind clkctl_top clkctl_chk #(.QUIET(128)) u_chk (
   .cfg_clk    (cfg_clk),
   .cfg_rst_n  (cfg_rst_n),
   .sel_hi_pin (sel_hi_pin),
   .ctl_byte   (ctl_byte),
   .pci_byte   (pci_byte),
   .cpu_byte   (cpu_byte),
   .aux_byte   (aux_byte),
   .freq_code  (freq_code),
   .ssc_en     (ssc_en),
   .test_mode  (test_mode),
   .out_hiz    (out_hiz),
   .cpu_clk_out(cpu_clk_out),
   .pci_clk_out(pci_clk_out),
   .ref_clk_out(ref_clk_out),
   .strap_q    (strap_q)
);

// File: tb/clkctl_top_test.sv
`timescale 1ns/1ps
module clkctl_top_test;
   logic cfg_clk = 1'b0, cpu_ck = 1'b0, pci_ck = 1'b0, apic_ck = 1'b0;
   logic ref_ck = 1'b0, ck48 = 1'b0, ck24 = 1'b0;
   logic rst_n, sel_pin, strap;
   logic [7:0] ctl, pci, cpu, aux;
   logic [2:0] freq_code;
   logic ssc_en, test_mode, out_hiz, apic_o, ref_o, sel_o;
   logic [1:0] cpu_o;
   logic [6:0] pci_o;

   int vectors = 0, miscompares = 0;
   bit finished = 0, mon_on = 0, strap_at_rst;

   always #2    cfg_clk = ~cfg_clk;   // 250 MHz
   always #5    cpu_ck  = ~cpu_ck;
   always #15   pci_ck  = ~pci_ck;
   always #7    apic_ck = ~apic_ck;
   always #35   ref_ck  = ~ref_ck;
   always #10   ck48    = ~ck48;
   always #20   ck24    = ~ck24;

   clkctl_top uut (
      .cfg_clk(cfg_clk), .cfg_rst_n(rst_n), .sel_hi_pin(sel_pin), .strap_pin(strap),
      .ctl_byte(ctl), .pci_byte(pci), .cpu_byte(cpu), .aux_byte(aux),
      .cpu_clk_in(cpu_ck), .pci_clk_in(pci_ck), .apic_clk_in(apic_ck), .ref_clk_in(ref_ck),
      .clk48_in(ck48), .clk24_in(ck24),
      .freq_code(freq_code), .ssc_en(ssc_en), .test_mode(test_mode), .out_hiz(out_hiz),
      .cpu_clk_out(cpu_o), .pci_clk_out(pci_o), .apic_clk_out(apic_o),
      .ref_clk_out(ref_o), .sel_clk_out(sel_o));

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // expected enable vector {apic, ref, pci[6:0], cpu[1:0]} from the requirements
   function automatic logic [10:0] exp_en(input logic [7:0] c, p, u, a);
      logic hz = (c[1:0] == 2'b11);
      logic [6:0] pm = {p[7], p[6], p[5], p[3], p[2], p[1], p[0]};
      logic [1:0] cm = {u[2], u[0]};
      logic rf = a[1] & a[0];
      return {a[5], rf, pm, cm} & {11{~hz}};
   endfunction

   // samples at x.5 ns so no clock edge coincides
   task automatic window(input string req, input int samples);
      logic [10:0] en = exp_en(ctl, pci, cpu, aux);
      for (int s = 0; s < samples; s++) begin
         logic [11:0] act, exp;
         act = {sel_o, apic_o, ref_o, pci_o, cpu_o};
         exp = {(strap_at_rst ? ck24 : ck48),
                en[10] & apic_ck, en[9] & ref_ck, en[8:2] & {7{pci_ck}}, en[1:0] & {2{cpu_ck}}};
         chk(act == exp, req, 16'(act), 16'(exp));
         #1;
      end
   endtask

   task automatic do_reset(input bit s);
      mon_on = 0;
      strap = s;
      rst_n = 1'b0;
      repeat (20) @(posedge cfg_clk);
      #0.5;
      strap_at_rst = s;
      chk({cpu_o, pci_o, apic_o, ref_o} == '0, "R10 outputs low in reset",
          16'({cpu_o, pci_o, apic_o, ref_o}), 16'h0);
      rst_n = 1'b1;
      #400;
      mon_on = 1;
   endtask

   // R9: a gated high pulse is a full input high phase
   realtime t_cpu, t_pci, t_ref;
   always @(posedge cpu_o[0]) t_cpu = $realtime;
   always @(negedge cpu_o[0]) if (mon_on && rst_n)
      chk(($realtime - t_cpu) > 4.99 && ($realtime - t_cpu) < 5.01, "R9 cpu pulse width",
          16'(int'($realtime - t_cpu)), 16'd5);
   always @(posedge pci_o[6]) t_pci = $realtime;
   always @(negedge pci_o[6]) if (mon_on && rst_n)
      chk(($realtime - t_pci) > 14.99 && ($realtime - t_pci) < 15.01, "R9 pci pulse width",
          16'(int'($realtime - t_pci)), 16'd15);
   always @(posedge ref_o) t_ref = $realtime;
   always @(negedge ref_o) if (mon_on && rst_n)
      chk(($realtime - t_ref) > 34.99 && ($realtime - t_ref) < 35.01, "R9 ref pulse width",
          16'(int'($realtime - t_ref)), 16'd35);

   initial begin
      ctl = 8'h00; pci = 8'hFF; cpu = 8'hFF; aux = 8'hFF; sel_pin = 1'b1;
      do_reset(1'b1);
      // R8: strap 1 selects 24 MHz; later pin changes ignored
      window("R8 strap=1 selects 24", 100);
      strap = 1'b0;
      #100;
      window("R8 strap ignored after reset", 100);

      // R1/R2/R3/R6: sweep source, code, pin, mode and reserved bits
      for (int n = 0; n < 128; n++) begin
         logic [2:0] exp_code;
         logic [2:0] exp_flags;
         ctl = {n[0], n[6:4], n[3], n[1], n[2] ? 2'b11 : 2'b00};
         ctl[1:0] = n[2:1];
         ctl[7] = n[0]; ctl[2] = n[1] ^ n[6];
         sel_pin = n[0] ^ n[5];
         #1;
         exp_code = ctl[3] ? ctl[6:4] : (sel_pin ? 3'b111 : 3'b011);
         exp_flags = {ctl[1:0] == 2'b10, ctl[1:0] == 2'b01, ctl[1:0] == 2'b11};
         chk(freq_code == exp_code, ctl[3] ? "R2 register code" : "R1 pin code",
             16'(freq_code), 16'(exp_code));
         chk({ssc_en, test_mode, out_hiz} == exp_flags, "R3 mode flags (R6 reserved)",
             16'({ssc_en, test_mode, out_hiz}), 16'(exp_flags));
      end

      // R4/R5/R6/R9: sweep all enable patterns, reserved bits varied
      ctl = 8'h84;
      for (int v = 0; v < 256; v++) begin
         pci = 8'(v);
         cpu = 8'(v * 37 + 3);
         aux = 8'(v * 91) ^ 8'hC8;
         #400;
         window("R4/R5 enable map", 70);
      end

      // R7: float mode overrides all enables
      pci = 8'hFF; cpu = 8'hFF; aux = 8'hFF; ctl = 8'h03;
      #400;
      window("R7 float forces low", 140);
      ctl = 8'h00;
      #400;
      window("R7 float released", 140);

      // R8: reset again with strap 0 selects 48 MHz
      do_reset(1'b0);
      window("R8 strap=0 selects 48", 100);
      finished = 1;
   end

   initial begin
      fork
         wait (finished);
         begin
            repeat (200000) @(posedge cfg_clk);
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=done");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule